// File: doc/BRIEF.md
# Successive-Approximation Control Register

This block steers an N-bit successive-approximation conversion. The converter's trial word lives in N state flip-flops. No separate one-hot step counter exists. The bit under trial is found from the word itself: it is the lowest-order bit that holds a 1. Every bit above it is already decided, and every bit below it is still 0 and has not been tried.

Each bit has its own small selector with three sources:

- **Shift:** set the bit to 1 because the bit above it is the one under trial.
- **Decide:** take the inverted comparator result.
- **Hold:** keep the current value.

The selector choice is made only from the present register contents. The trial word drives the external reference network. The comparator answers once per clock. After N steps the word holds the converted code and a one-cycle done pulse is raised.

A synchronous start loads the initial word (MSB set, all other bits clear) on the next clock edge. Start may be raised at any time. If it arrives during a conversion, that conversion is abandoned.

Top module: `sar_min_reg`

## Requirements
- R1: While `rst_n` is low, `result` reads all zeros and `done` is low.
- R2: A clock edge with `start` high loads `result` with only bit N-1 set and drives `done` low.
- R3: On each conversion step, the trial bit (the lowest set bit of `result`) becomes the inverse of `cmp`. A `cmp` of 1 means the trial word exceeds the input and clears the bit. Bits above the trial bit keep their values.
- R4: On the same step, when the trial bit is not bit 0, the bit just below it is set to 1 and becomes the next trial bit. Lower bits stay 0.
- R5: The N-th step after start resolves bit 0 and raises `done` for exactly one cycle. With an ideal comparator (`cmp` = 1 when `result` > input code), `result` then equals the input code.
- R6: Once a conversion has ended, `result` holds its value and `done` stays low until the next start, whatever `cmp` does.
- R7: A start raised during a conversion abandons it. The next edge reloads the initial word, and the following conversion completes normally without an early `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Synchronous conversion start / restart |
| cmp | input | 1 | Comparator decision for the present trial word (1 = trial too large) |
| result | output | N | Trial word during conversion, final code afterwards |
| done | output | 1 | One-cycle pulse after the last bit is decided |

## Verification
The bench converts every input code and then a seeded random set of codes against an ideal comparator. It checks the trial word after every step, not only the final code.

A selector that picked the wrong source would corrupt the partial words. One example is a hold taken where a shift was due: the lowest set bit would be lost and the conversion would stall.

An end-of-conversion test on the wrong bit would show up in the endpoint codes. Codes 0 and 2^N-1, and codes whose low bits are all 0 or all 1, would pulse `done` too early or never.

Restarts are injected at random step positions. They catch a register that merges the old word into the new one, or that lets the old step count finish early. Comparator activity while idle checks that a finished result cannot be disturbed.

// File: rtl/sar_min_pkg.sv
package sar_min_pkg;

  // Source selected for the next value of one register bit
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_SHIFT = 2'd1,
    SRC_DECIDE = 2'd2
  } bit_src_e;

  // Selector rule: a bit under trial takes the decision, the bit just
  // below an active trial bit is switched on, everything else holds.
  function automatic bit_src_e pick_src(input logic own_trial,
                                        input logic upper_trial);
    if (own_trial)        return SRC_DECIDE;
    else if (upper_trial) return SRC_SHIFT;
    else                  return SRC_HOLD;
  endfunction

endpackage

// File: rtl/sar_trial_locate.sv
module sar_trial_locate #(
  parameter int N = 8
) (
  input  logic [N-1:0] word,
  output logic [N-1:0] trial_mask
);
  localparam logic [N-1:0] ONE_N = N'(1);

  // Lowest set bit isolated by two's-complement masking
  always_comb trial_mask = word & (~word + ONE_N);
endmodule

// File: rtl/sar_bit_cell.sv
module sar_bit_cell
  import sar_min_pkg::*;
#(
  parameter logic INIT_BIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic busy,
  input  logic own_trial,
  input  logic upper_trial,
  input  logic cmp,
  output logic q
);
  bit_src_e src;

  always_comb src = pick_src(own_trial, upper_trial);

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 1'b0;
    else if (start) q <= INIT_BIT;
    else if (busy) begin
      case (src)
        SRC_SHIFT:  q <= 1'b1;
        SRC_DECIDE: q <= ~cmp;
        default:    q <= q;
      endcase
    end
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic lsb_trial,
  output logic busy,
  output logic done
);
  logic last_step;

  always_comb last_step = busy & lsb_trial;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= ~start & last_step;
      if (start)          busy <= 1'b1;
      else if (last_step) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_min_reg.sv
module sar_min_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         cmp,
  output logic [N-1:0] result,
  output logic         done
);
  logic [N-1:0] trial_mask;
  logic [N-1:0] upper_trial;
  logic         busy;

  sar_trial_locate #(.N(N)) u_locate (
    .word       (result),
    .trial_mask (trial_mask)
  );

  sar_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .lsb_trial (trial_mask[0]),
    .busy      (busy),
    .done      (done)
  );

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_bit
      if (k == N - 1) begin : g_top
        assign upper_trial[k] = 1'b0;
      end else begin : g_low
        assign upper_trial[k] = trial_mask[k+1];
      end

      sar_bit_cell #(.INIT_BIT(k == N - 1)) u_cell (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .busy        (busy),
        .own_trial   (trial_mask[k]),
        .upper_trial (upper_trial[k]),
        .cmp         (cmp),
        .q           (result[k])
      );
    end
  endgenerate
endmodule

// File: rtl/sar_min_reg_chk.sv
module sar_min_reg_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         cmp,
  input logic [N-1:0] result,
  input logic         done,
  input logic         busy,
  input logic [N-1:0] trial_mask
);
  localparam logic [N-1:0] ONE_N  = N'(1);
  localparam logic [N-1:0] INIT_W = ONE_N << (N - 1);

  logic [N-1:0] above_mask;
  logic         stepping;

  assign above_mask = ~((trial_mask << 1) - ONE_N);
  assign stepping   = busy & ~start;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (result == '0) && !done);                                   // R1

  AST_START_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (result == INIT_W) && !done && busy);                        // R2

  AST_ONE_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(trial_mask) == 1);                                 // R3

  AST_TRIAL_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
    stepping |=> ((result & $past(trial_mask)) != '0) == !$past(cmp));     // R3

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    stepping |=> (result & $past(above_mask)) == ($past(result) & $past(above_mask))); // R3

  AST_NEXT_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && !trial_mask[0]) |=> (result & ($past(trial_mask) >> 1)) != '0); // R4

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && trial_mask[0]) |=> done && !busy);                        // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                       // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result) && !done);                       // R6

  AST_ABORT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> (result == INIT_W) && busy && !done);              // R7
endmodule

bind sar_min_reg sar_min_reg_chk #(.N(N)) u_chk (.*);

// File: tb/test_sar_min_reg.sv
module test_sar_min_reg;
  localparam int N          = 8;
  localparam int CLK_PERIOD = 10;
  localparam int NCODES     = 1 << N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] vin = '0;
  logic [N-1:0] result;
  logic         done;
  logic         cmp;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Ideal comparator: 1 when the trial word exceeds the input code
  assign cmp = (result > vin);

  sar_min_reg #(.N(N)) i_sar_min_reg (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp(cmp),
    .result(result), .done(done)
  );

  // Expected word after j steps of converting code
  function automatic int exp_word(int code, int j);
    int upper;
    if (j >= N) return code;
    upper = (code >> (N - j)) << (N - j);
    return upper | (1 << (N - 1 - j));
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_conv(int code, string init_tag);
    @(negedge clk);
    start = 1'b1;
    vin   = N'(code);
    @(negedge clk);
    start = 1'b0;
    chk(init_tag, int'(result), exp_word(code, 0));
    chk(init_tag, int'(done), 0);
    for (int j = 1; j <= N; j++) begin
      @(negedge clk);
      if (j < N) begin
        chk("R3", int'(result), exp_word(code, j));   // R3 / R4 partial word
        chk("R4", int'(done), 0);
      end else begin
        chk("R5", int'(result), code);
        chk("R5", int'(done), 1);
      end
    end
    @(negedge clk);
    chk("R5", int'(done), 0);
    chk("R6", int'(result), code);
  endtask

  task automatic run_abort(int a, int b, int steps);
    @(negedge clk);
    start = 1'b1;
    vin   = N'(a);
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < steps; s++) begin
      @(negedge clk);
      chk("R4", int'(done), 0);
    end
    run_conv(b, "R7");
  endtask

  task automatic idle_disturb(int code);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      vin = N'($urandom);
      chk("R6", int'(result), code);
      chk("R6", int'(done), 0);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  initial begin
    int seed_set;
    seed_set = $urandom(32'h5A17);
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", int'(result), 0);
    chk("R1", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(result), 0);

    // Directed corners, then full sweep (R2..R5)
    run_conv(0, "R2");
    run_conv(NCODES - 1, "R2");
    run_conv(1, "R2");
    run_conv(NCODES / 2, "R2");
    run_conv(NCODES / 2 - 1, "R2");
    idle_disturb(NCODES / 2 - 1);
    for (int c = 0; c < NCODES; c++) run_conv(c, "R2");
    idle_disturb(NCODES - 1);

    // Restart mid-conversion (R7)
    run_abort(NCODES - 1, 0, 0);
    run_abort(0, NCODES - 1, N - 2);
    for (int i = 0; i < 40; i++)
      run_abort($urandom % NCODES, $urandom % NCODES, $urandom % (N - 1));

    // Random codes with idle disturbance (R5, R6)
    for (int i = 0; i < 300; i++) begin
      int code;
      code = $urandom % NCODES;
      run_conv(code, "R2");
      if (i % 25 == 0) idle_disturb(code);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R5: watchdog expired, got running expected finished");
      summary();
      $finish;
    end
  end
endmodule